// File: doc/BRIEF.md
# Clock-Configuration Watchdog with Safe-Code Fallback

This block guards a clock configuration controller against a system that stops responding. Software loads an 8-bit timeout count, expressed in fixed time units of `UNIT_CYCLES` system clocks (290 ms at the intended clock rate). It then arms the watchdog and has to rewrite the count before the time runs out. If software fails to do so, the block latches an alarm flag. It also drives an active-low system reset pulse of `RST_CYCLES` clocks. While the alarm is set, it replaces the live frequency-select code with a 5-bit safe code held in its own control register.

The arm decision has two sources. After reset it follows a strap-latched enable pin. Once software has written the control byte, it follows the software enable bit. The register write strobes come from a serial-bus front end outside this block. The frequency code goes on to the synthesizer, which is also outside this block.

Top module: `clkcfg_watchdog`

## Requirements
- R1: After reset the count readback is 16 (`CNT_RESET`), control readback bits 7, 5 and 4:0 are 0, bit 6 equals `strap_wd_en`, `sys_rst_n` is 1 and `freq_sel_out` equals `freq_sel_in`.
- R2: The effective enable, shown on `ctl_q[6]`, follows `strap_wd_en` until the first control write, and from then on follows control bit 6 (1 = armed).
- R3: With the watchdog armed and count N ≥ 1 written, the alarm becomes visible after exactly N·`UNIT_CYCLES`+1 clock edges, counted from the write edge.
- R4: Any write to the count register reloads the full timeout and restarts the unit prescaler, so rewriting it in time keeps the alarm clear.
- R5: A count of 0 with the watchdog armed raises the alarm on the first clock edge at which the armed state is seen.
- R6: The alarm, read on `ctl_q[5]`, is sticky. Only a control write with bit 5 = 0 clears it, and writing 1 to bit 5 never sets it.
- R7: If a timeout and an alarm-clearing control write fall on the same edge, the alarm ends up set.
- R8: If a count write falls on the edge at which a timeout would fire, the reload wins and no alarm or reset pulse occurs.
- R9: Every timeout drives `sys_rst_n` low for exactly `RST_CYCLES` cycles, starting on the timeout edge.
- R10: `freq_sel_out` equals the safe code (control bits 4:0) while the alarm is set, and `freq_sel_in` otherwise.
- R11: While disarmed, no timeout occurs and the timer stays loaded with the count register, so arming starts a full period.
- R12: Control bit 7 (programming enable) resets to 0, and control writes store and read back bits 7 and 4:0 as written.
- R13: After a timeout the watchdog stays expired and fires no further pulse until the count register is written or the watchdog is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_wd_en | input | 1 | Strap-latched enable, used until software writes the control byte |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Count write data (timeout in units) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [7] program enable, [6] arm, [5] alarm clear-by-zero, [4:0] safe code |
| freq_sel_in | input | 5 | Live frequency-select code |
| count_q | output | CNT_W | Count register readback |
| ctl_q | output | 8 | Control readback: [7] program enable, [6] effective enable, [5] alarm, [4:0] safe code |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| freq_sel_out | output | 5 | Frequency-select code after fallback |

## Verification
Two pairs of functions can land on the same clock edge, and the bench tests both. In the first pair, the timeout fires on the same edge that software writes the control byte with a zero in the alarm position. In the second pair, the timeout fires on the same edge that software rewrites the count. In each case the bench places the write exactly N·`UNIT_CYCLES`+1 edges after a count load, so that it lands on the firing edge. It then reads the alarm bit and the reset line at the next sample. The alarm must stay set in the first case. In the second case no alarm and no pulse may appear, and a fresh full period must follow. A behavioural model that counts remaining cycles is compared against every output on every clock.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;
   // control byte layout, decoded by the register front end
   localparam int CTL_PROG_BIT  = 7;
   localparam int CTL_ARM_BIT   = 6;
   localparam int CTL_ALARM_BIT = 5;
   localparam int SAFE_W        = 5;

   typedef struct packed {
      logic              prog_en;
      logic              arm;
      logic              alarm;
      logic [SAFE_W-1:0] safe;
   } ctl_byte_t;
endpackage

// File: rtl/clkwd_prescaler.sv
module clkwd_prescaler #(
   parameter int UNIT_CYCLES = 14_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (UNIT_CYCLES < 1) begin : g_bad_unit
      $error("UNIT_CYCLES must be at least 1");
   end

   if (UNIT_CYCLES == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int PW = $clog2(UNIT_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(UNIT_CYCLES - 1);
      logic [PW-1:0] pre_q;
      logic          wrap;

      assign wrap = (pre_q == LAST);
      assign tick = run & wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pre_q <= '0;
         else if (!run)       pre_q <= '0;
         else if (wrap)       pre_q <= '0;
         else                 pre_q <= pre_q + 1'b1;
      end

      // R3
      pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> pre_q == '0);
   end
endmodule

// File: rtl/clkwd_downcount.sv
module clkwd_downcount #(
   parameter int CNT_W     = 8,
   parameter int CNT_RESET = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] hold_val,
   input  logic             tick,
   output logic             counting,
   output logic             fire,
   output logic             expired
);
   logic [CNT_W-1:0] rem_q;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             at_zero;

   assign load     = wr | ~armed;
   assign load_val = wr ? wdata : hold_val;
   assign at_zero  = (rem_q == '0);
   assign fire     = armed & ~wr & ~expired & at_zero;
   assign counting = armed & ~wr & ~expired & ~at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= CNT_W'(CNT_RESET);
         expired <= 1'b0;
      end else if (load) begin
         rem_q   <= load_val;
         expired <= 1'b0;
      end else if (fire) begin
         expired <= 1'b1;
      end else if (tick) begin
         rem_q   <= rem_q - 1'b1;
      end
   end

   // R3
   rem_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> rem_q <= $past(rem_q));
   // R13
   expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);
endmodule

// File: rtl/clkwd_rst_stretch.sv
module clkwd_rst_stretch #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic rst_out_n
);
   if (RST_CYCLES < 1) begin : g_bad_len
      $error("RST_CYCLES must be at least 1");
   end

   if (RST_CYCLES == 1) begin : g_single
      logic low_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) low_q <= 1'b0;
         else        low_q <= trig;
      end
      assign rst_out_n = ~low_q;
   end else begin : g_counter
      localparam int RW = $clog2(RST_CYCLES + 1);
      logic [RW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (trig)           left_q <= RW'(RST_CYCLES);
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
      assign rst_out_n = (left_q == '0);
   end

   // R9
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !rst_out_n);
   // R9
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out_n) |-> $past(trig));
endmodule

// File: rtl/clkcfg_watchdog.sv
module clkcfg_watchdog
   import clkwd_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int UNIT_CYCLES = 14_500_000,
   parameter int CNT_RESET   = 16,
   parameter int RST_CYCLES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_wd_en,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   input  logic [SAFE_W-1:0] freq_sel_in,
   output logic [CNT_W-1:0]  count_q,
   output logic [7:0]        ctl_q,
   output logic              sys_rst_n,
   output logic [SAFE_W-1:0] freq_sel_out
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
      $error("CNT_W out of range");
   end
   if (CNT_RESET < 0 || CNT_RESET >= (1 << CNT_W)) begin : g_bad_rst
      $error("CNT_RESET does not fit CNT_W");
   end

   ctl_byte_t        wr_byte;
   logic [CNT_W-1:0] count_reg;
   logic             prog_en_q, sw_arm_q, sw_seen_q, alarm_q;
   logic [SAFE_W-1:0] safe_q;
   logic             wd_en, counting, tick, fire, expired;

   assign wr_byte = ctl_wdata;
   assign wd_en   = sw_seen_q ? sw_arm_q : strap_wd_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_reg <= CNT_W'(CNT_RESET);
         prog_en_q <= 1'b0;
         sw_arm_q  <= 1'b0;
         sw_seen_q <= 1'b0;
         safe_q    <= '0;
      end else begin
         if (cnt_wr) count_reg <= cnt_wdata;
         if (ctl_wr) begin
            prog_en_q <= wr_byte.prog_en;
            sw_arm_q  <= wr_byte.arm;
            sw_seen_q <= 1'b1;
            safe_q    <= wr_byte.safe;
         end
      end
   end

   // alarm: set by a timeout, cleared only by writing zero; set wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          alarm_q <= 1'b0;
      else if (fire)                       alarm_q <= 1'b1;
      else if (ctl_wr && !wr_byte.alarm)   alarm_q <= 1'b0;
   end

   clkwd_downcount #(.CNT_W(CNT_W), .CNT_RESET(CNT_RESET)) u_count (
      .clk(clk), .rst_n(rst_n), .armed(wd_en), .wr(cnt_wr),
      .wdata(cnt_wdata), .hold_val(count_reg), .tick(tick),
      .counting(counting), .fire(fire), .expired(expired));

   clkwd_prescaler #(.UNIT_CYCLES(UNIT_CYCLES)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(counting), .tick(tick));

   clkwd_rst_stretch #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk(clk), .rst_n(rst_n), .trig(fire), .rst_out_n(sys_rst_n));

   assign count_q      = count_reg;
   assign ctl_q        = {prog_en_q, wd_en, alarm_q, safe_q};
   assign freq_sel_out = alarm_q ? safe_q : freq_sel_in;

   // R6
   alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_q) |-> $past(fire));
   // R7
   alarm_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> alarm_q);
   // R8
   reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> !expired);
   // R11
   disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en |-> !fire);
endmodule

// File: tb/clkcfg_watchdog_tb.sv
module clkcfg_watchdog_tb;
   localparam int U   = 4;
   localparam int RST = 3;
   localparam int CR  = 16;

   logic       clk = 0, rst_n = 0, strap = 0, cnt_wr = 0, ctl_wr = 0;
   logic [7:0] cnt_wdata = 0, ctl_wdata = 0;
   logic [4:0] fin = 5'h0A;
   logic [7:0] count_q, ctl_q;
   logic       sys_rst_n;
   logic [4:0] fout;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   clkcfg_watchdog #(.CNT_W(8), .UNIT_CYCLES(U), .CNT_RESET(CR), .RST_CYCLES(RST)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_wd_en(strap), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .freq_sel_in(fin), .count_q(count_q), .ctl_q(ctl_q),
      .sys_rst_n(sys_rst_n), .freq_sel_out(fout));

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference: remaining time kept in cycles
   int  m_count, m_left, m_rstc;
   bit  m_exp, m_alarm, m_prog, m_swen, m_seen, m_en, m_fire;
   bit [4:0] m_safe;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_count = CR; m_left = CR * U; m_rstc = 0;
         m_exp = 0; m_alarm = 0; m_prog = 0; m_swen = 0; m_seen = 0; m_safe = 0;
      end else begin
         m_en   = m_seen ? m_swen : strap;
         m_fire = m_en && !m_exp && !cnt_wr && m_left == 0;
         if (cnt_wr) begin
            m_count = cnt_wdata; m_left = cnt_wdata * U; m_exp = 0;
         end else if (!m_en) begin
            m_left = m_count * U; m_exp = 0;
         end else if (m_fire) m_exp = 1;
         else if (!m_exp) m_left = m_left - 1;
         if (m_fire) m_alarm = 1;
         else if (ctl_wr && !ctl_wdata[5]) m_alarm = 0;
         if (ctl_wr) begin
            m_prog = ctl_wdata[7]; m_swen = ctl_wdata[6]; m_seen = 1; m_safe = ctl_wdata[4:0];
         end
         if (m_fire) m_rstc = RST;
         else if (m_rstc > 0) m_rstc = m_rstc - 1;
      end
   end

   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         chk("R4 count_q", count_q, m_count);
         chk("R6 ctl_q", ctl_q, {m_prog, (m_seen ? m_swen : strap), m_alarm, m_safe});
         chk("R9 sys_rst_n", sys_rst_n, (m_rstc == 0));
         chk("R10 freq_sel_out", fout, m_alarm ? m_safe : fin);
      end
   end

   task automatic wr_cnt(input logic [7:0] v);
      cnt_wdata = v; cnt_wr = 1;
      @(negedge clk); cnt_wr = 0;
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wdata = v; ctl_wr = 1;
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic edges_to_alarm(output int n);
      n = 0;
      while (!ctl_q[5] && n < 2000) begin @(negedge clk); n++; end
   endtask

   task automatic low_len(output int k);
      k = 0;
      while (!sys_rst_n && k < 100) begin k++; @(negedge clk); end
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      finish_run();
   end

   initial begin
      int n, k, lows;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", count_q, 16);
      chk("R1 ctl", ctl_q, 8'h00);
      chk("R1 rst", sys_rst_n, 1);
      chk("R1 freq", fout, 5'h0A);
      // R11 disarmed: nothing happens
      repeat (100) @(negedge clk);
      chk("R11 no alarm", ctl_q[5], 0);
      // R2 strap arms, R3 full period of the reset count
      strap = 1;
      edges_to_alarm(n);
      chk("R2 R3 strap timeout edges", n, CR * U + 1);
      chk("R10 safe code", fout, 5'h00);
      low_len(k);
      chk("R9 pulse length", k, RST);
      // R13 no second pulse while expired
      lows = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (!sys_rst_n) lows++; end
      chk("R13 no repeat", lows, 0);
      // R6 writing 1 keeps alarm, R12 fields stored
      wr_ctl(8'hE5);
      chk("R6 R12 ctl keep", ctl_q, 8'hE5);
      chk("R10 new safe", fout, 5'h05);
      wr_ctl(8'hC5);
      chk("R6 cleared", ctl_q, 8'hC5);
      chk("R10 live freq", fout, 5'h0A);
      // R2 software arm overrides strap
      strap = 0;
      wr_cnt(8'd2);
      edges_to_alarm(n);
      chk("R2 R3 count2 edges", n, 2 * U + 1);
      wr_ctl(8'hC5);
      // R4 servicing keeps alarm clear
      wr_cnt(8'd3);
      for (int i = 0; i < 5; i++) begin repeat (9) @(negedge clk); wr_cnt(8'd3); end
      chk("R4 serviced", ctl_q[5], 0);
      edges_to_alarm(n);
      chk("R4 R3 count3 edges", n, 3 * U + 1);
      // R11 disarmed with count 0, R5 immediate on arming
      wr_ctl(8'h85);
      wr_cnt(8'd0);
      repeat (10) @(negedge clk);
      chk("R11 disarmed zero", ctl_q[5], 0);
      chk("R12 prog bit", ctl_q[7], 1);
      wr_ctl(8'hC5);
      edges_to_alarm(n);
      chk("R5 zero count edges", n, 1);
      repeat (5) @(negedge clk);
      // R7 timeout and clear on the same edge
      wr_ctl(8'hC5);
      chk("R7 pre clear", ctl_q[5], 0);
      wr_cnt(8'd1);
      repeat (U) @(negedge clk);
      wr_ctl(8'hC5);
      chk("R7 set wins", ctl_q[5], 1);
      chk("R7 pulse", sys_rst_n, 0);
      repeat (5) @(negedge clk);
      // R8 reload on the firing edge
      wr_ctl(8'hC5);
      wr_cnt(8'd1);
      repeat (U) @(negedge clk);
      wr_cnt(8'd1);
      chk("R8 no alarm", ctl_q[5], 0);
      chk("R8 no pulse", sys_rst_n, 1);
      edges_to_alarm(n);
      chk("R8 fresh period", n, U + 1);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule